// File: doc/BRIEF.md
# Masked Open-Drain Two-Line Pin Register

This block is a single 32-bit register that lets software bit-bang a two-wire bus made of a clock line and a data line. Neither line is ever driven high. A line goes high when its driver turns off and the external pull-up takes over. It goes low when the driver turns on with a value of 0. Each line has a stored direction bit and a stored output value bit. Each of these bits has its own write-enable (mask) bit in the same word, so one write can move one line without touching the other. Software therefore never has to read the register, modify it and write it back.

The level on each line passes through a two-flop synchronizer and can be read in the same word. Software first releases a line by writing its direction mask with direction "input", then reads the level. Two pull-up-disable bits are plain storage: software reads them and writes them back. Bus sequencing (start, stop, acknowledge) is the host's job and is not part of this block.

Bit map: the clock line occupies bits 4..0 and the data line bits 12..8. Within each line field, offset 0 is the direction mask, offset 1 is the direction (1 = drive), offset 2 is the value mask, offset 3 is the value, and offset 4 is the synchronized input level. Bit 16 is the clock-line pull-up-disable bit and bit 17 is the data-line pull-up-disable bit. All other bits read 0.

Top module: `odpin_ctl_reg`

## Requirements
- R1: A write with a line's direction mask (offset 0) at 1 loads that line's direction bit (offset 1) from the written word. The new value is visible on the read port and output enable after that clock edge.
- R2: A write with a line's direction mask at 0 leaves that line's direction bit unchanged, whatever the written direction bit is.
- R3: A write with a line's value mask (offset 2) at 1 loads that line's value bit (offset 3) from the written word.
- R4: A write with a line's value mask at 0 leaves that line's value bit unchanged.
- R5: Each line's output enable equals its stored direction bit and its output value equals its stored value bit. Direction 1 with value 0 pulls the line low, and direction 0 releases it.
- R6: Bits 16 and 17 are loaded from every write and hold their value when there is no write.
- R7: The input bit (offset 4) of each line reads the line level sampled two clock edges earlier.
- R8: Mask bits, input bits and unused bits ignore writes to them. Mask bits and unused bits always read 0, and input bits read only the sampled line level.
- R9: While reset is asserted, and again after it, both lines are released (output enable 0) with value 0, the pull-up-disable bits are 0 and the input bits read 0. Reset takes effect at once, without a clock.
- R10: A masked write to one line changes neither the direction nor the value of the other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write word |
| rd_data | output | 32 | Current register contents |
| ck_oe | output | 1 | Clock-line driver enable (low drive) |
| ck_out | output | 1 | Clock-line driven value |
| ck_in | input | 1 | Clock-line sensed level |
| dt_oe | output | 1 | Data-line driver enable (low drive) |
| dt_out | output | 1 | Data-line driven value |
| dt_in | input | 1 | Data-line sensed level |

## Verification
The hardest case to reach is a write that carries real-looking direction and value bits while their masks are clear. A plain walk of values never tells a masked-off field apart from one that happened to hold the same value already. The stimulus first sets both lines to drive with value 1. It then writes all ones except the four mask bits, and then all four masks with zero values. This shows that only the masked fields move, and that each line stays independent of the other. The two-edge input lag is checked by changing a line level at a falling edge and sampling after one rising edge and again after two.

// File: rtl/odpin_pkg.sv
package odpin_pkg;
  localparam int REG_W      = 32;
  localparam int PIN_COUNT  = 2;
  localparam int PIN_STRIDE = 8;
  localparam int OFS_DIRM   = 0;
  localparam int OFS_DIR    = 1;
  localparam int OFS_VALM   = 2;
  localparam int OFS_VAL    = 3;
  localparam int OFS_IN     = 4;
  localparam int PU_BASE    = 16;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic dir_m;
    logic dir;
    logic val_m;
    logic val;
  } pin_cmd_t;
endpackage

// File: rtl/odpin_rst_sync.sv
module odpin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/odpin_sync.sv
module odpin_sync #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain_q [DEPTH];
  logic [WIDTH-1:0] chain_d [DEPTH];

  always_comb begin
    chain_d[0] = din;
    for (int s = 1; s < DEPTH; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) chain_q[s] <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) chain_q[s] <= chain_d[s];
    end
  end

  assign dout = chain_q[DEPTH-1];
endmodule

// File: rtl/odpin_lane.sv
module odpin_lane
  import odpin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pin_cmd_t cmd,
  output logic     dir_q,
  output logic     val_q
);
  logic dir_en, val_en;
  logic dir_d, val_d;

  always_comb begin
    dir_en = wr_en & cmd.dir_m;
    val_en = wr_en & cmd.val_m;
    dir_d  = cmd.dir;
    val_d  = cmd.val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      val_q <= 1'b0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (val_en) val_q <= val_d;
    end
  end

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd.dir_m) |=> (dir_q == $past(cmd.dir))); // R1
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cmd.dir_m) |=> $stable(dir_q)); // R2
  AST_VAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd.val_m) |=> (val_q == $past(cmd.val))); // R3
  AST_VAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cmd.val_m) |=> $stable(val_q)); // R4
endmodule

// File: rtl/odpin_ctl_reg.sv
module odpin_ctl_reg
  import odpin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             ck_oe,
  output logic             ck_out,
  input  logic             ck_in,
  output logic             dt_oe,
  output logic             dt_out,
  input  logic             dt_in
);
  logic                 rst_n_int;
  logic [PIN_COUNT-1:0] pin_in;
  logic [PIN_COUNT-1:0] in_sync;
  logic [PIN_COUNT-1:0] dir_q;
  logic [PIN_COUNT-1:0] val_q;
  logic [PIN_COUNT-1:0] pu_q;
  logic [PIN_COUNT-1:0] pu_d;
  logic                 pu_en;
  logic                 unused_wr;

  assign unused_wr = ^wr_data;
  assign pin_in    = {dt_in, ck_in};

  odpin_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  odpin_sync #(.WIDTH(PIN_COUNT), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (pin_in),
    .dout  (in_sync)
  );

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_lane
    pin_cmd_t cmd;
    assign cmd.dir_m = wr_data[p*PIN_STRIDE + OFS_DIRM];
    assign cmd.dir   = wr_data[p*PIN_STRIDE + OFS_DIR];
    assign cmd.val_m = wr_data[p*PIN_STRIDE + OFS_VALM];
    assign cmd.val   = wr_data[p*PIN_STRIDE + OFS_VAL];

    odpin_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n_int),
      .wr_en (wr_en),
      .cmd   (cmd),
      .dir_q (dir_q[p]),
      .val_q (val_q[p])
    );
  end

  always_comb begin
    pu_en = wr_en;
    pu_d  = wr_data[PU_BASE +: PIN_COUNT];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  pu_q <= '0;
    else if (pu_en)  pu_q <= pu_d;
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < PIN_COUNT; p++) begin
      rd_data[p*PIN_STRIDE + OFS_DIR] = dir_q[p];
      rd_data[p*PIN_STRIDE + OFS_VAL] = val_q[p];
      rd_data[p*PIN_STRIDE + OFS_IN]  = in_sync[p];
      rd_data[PU_BASE + p]            = pu_q[p];
    end
  end

  assign ck_oe  = dir_q[0];
  assign ck_out = val_q[0];
  assign dt_oe  = dir_q[1];
  assign dt_out = val_q[1];

  logic [1:0] chk_age_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)              chk_age_q <= 2'd0;
    else if (chk_age_q != 2'd2)  chk_age_q <= chk_age_q + 2'd1;
  end

  AST_PU_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    !wr_en |=> $stable(rd_data[PU_BASE +: PIN_COUNT])); // R6
  AST_CK_IN_LAG: assert property (@(posedge clk) disable iff (!rst_n_int)
    (chk_age_q == 2'd2) |-> (rd_data[OFS_IN] == $past(ck_in, 2))); // R7
  AST_DT_IN_LAG: assert property (@(posedge clk) disable iff (!rst_n_int)
    (chk_age_q == 2'd2) |-> (rd_data[PIN_STRIDE + OFS_IN] == $past(dt_in, 2))); // R7
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_data[OFS_DIRM] == 1'b0) && (rd_data[PIN_STRIDE + OFS_VALM] == 1'b0)); // R8
endmodule

// File: tb/odpin_ctl_reg_tb.sv
module odpin_ctl_reg_tb;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ck_oe, ck_out, ck_in;
  logic        dt_oe, dt_out, dt_in;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  // {write word, expected read word}; lines held high during the walk
  localparam logic [63:0] VEC [8] = '{
    {32'h0000_0003, 32'h0000_1012},  // R1 clock dir set
    {32'h0000_000C, 32'h0000_101A},  // R3 clock val set
    {32'h0000_0300, 32'h0000_121A},  // R2 R10 clock unmasked, data dir set
    {32'h0001_0004, 32'h0001_1212},  // R3 R6 clock val cleared, pull-up
    {32'h0002_0001, 32'h0002_1210},  // R1 R6 clock released
    {32'hFFFF_FFFF, 32'h0003_1A1A},  // R8 all ones: masks/reserved read 0
    {32'hFFFF_FAFA, 32'h0003_1A1A},  // R2 R4 masks clear, nothing moves
    {32'h0000_0505, 32'h0000_1010}   // R1 R3 R6 masks only, values 0
  };

  always #(CLK_T/2) clk = ~clk;

  odpin_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ck_oe(ck_oe), .ck_out(ck_out), .ck_in(ck_in),
    .dt_oe(dt_oe), .dt_out(dt_out), .dt_in(dt_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] pins();
    return {28'd0, ck_oe, ck_out, dt_oe, dt_out};
  endfunction

  initial begin
    #(CLK_T*5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ck_in = 1'b1; dt_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset rd", rd_data, 32'h0);
    chk("R9 reset pins", pins(), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 R7 after reset", rd_data, 32'h0000_1010);

    for (int k = 0; k < 8; k++) begin
      wr(VEC[k][63:32]);
      chk($sformatf("R1 R2 R3 R4 R6 R8 vec %0d", k), rd_data, VEC[k][31:0]);
      chk($sformatf("R5 pins vec %0d", k), pins(),
          {28'd0, VEC[k][31:0][1], VEC[k][31:0][3], VEC[k][31:0][9], VEC[k][31:0][11]});
    end

    // R5 drive clock low, then release
    wr(32'h0000_0007);
    chk("R5 clock low", pins(), 32'h8);
    wr(32'h0000_0001);
    chk("R5 clock release", pins(), 32'h0);

    // R7 input lag
    @(negedge clk); ck_in = 1'b0;
    @(negedge clk);
    chk("R7 ck one edge", {31'd0, rd_data[4]}, 32'd1);
    @(negedge clk);
    chk("R7 ck two edges", {31'd0, rd_data[4]}, 32'd0);
    dt_in = 1'b0;
    @(negedge clk);
    chk("R7 dt one edge", {31'd0, rd_data[12]}, 32'd1);
    @(negedge clk);
    chk("R7 dt two edges", {31'd0, rd_data[12]}, 32'd0);

    // R8 writing input bits with lines low has no effect
    wr(32'h0000_1010);
    chk("R8 input bits ignore write", rd_data, 32'h0);

    // R10 data-only write keeps clock state
    wr(32'h0000_000F);
    wr(32'h0000_0F00);
    chk("R10 data write keeps clock", rd_data, 32'h0000_0A0A);

    // R9 asynchronous reset mid-run
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset rd", rd_data, 32'h0);
    chk("R9 async reset pins", pins(), 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule